// File: doc/BRIEF.md
# Fixed-Direction GPIO Port with Edge Interrupts

A byte-wide, register-mapped general-purpose I/O port with eight lines and a fixed direction for each. Lines 0 to 3 are outputs driven from a software-written latch. Lines 4 to 7 are inputs. Each input passes through a two-flop synchroniser and can raise an interrupt on a rising edge, a falling edge or both, chosen separately for each input. Detected edges are latched as pending bits. Software clears them by writing ones back, and one interrupt line reports whether any bit is pending.

Software uses a synchronous byte bus. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational from the current address. In the usual flow, software sets the trigger field for each input, waits for `irq`, reads the pending register, and writes the same value back to acknowledge the events it has handled.

Top module: `fixgpio_irq`

## Requirements
- R1: While `rst` is high and directly after it falls, `pad_out` is 0, `irq` is 0, and the data, trigger and pending registers read 0 (with all pads low).
- R2: Offset 0 is a fixed direction word that always reads 0x0F (a set bit marks an output line). Writes to it change nothing.
- R3: A write to offset 1 copies `bus_wdata[3:0]` to `pad_out` at that clock edge and ignores bits 7:4. `pad_out` changes only on such writes.
- R4: A read of offset 1 returns the output latch in bits 3:0 and the synchronised level of `pad_in[3:0]` in bits 7:4. A pad change made before clock edge N is visible after edge N+1.
- R5: Offset 3 is a read/write trigger register. Input k uses bits 2k+1:2k. Field bit 1 enables rising edges and field bit 0 enables falling edges.
- R6: Field 10 reacts only to rising edges, 01 only to falling edges, 11 to both, and 00 to none. For a pad change made before edge N, the pending bit is set at edge N+2.
- R7: A read of offset 4 returns the pending bits in bits 3:0 and zeros above. A write to offset 4 clears each pending bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R8: If an enabled edge and a clear of the same pending bit fall on the same clock edge, the bit stays set.
- R9: `irq` is high exactly when at least one pending bit is set, in the same cycle.
- R10: Offsets 2, 5, 6 and 7 read as 0, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_out | output | 4 | Levels driven on output lines 0 to 3 |
| pad_in | input | 4 | Asynchronous levels of input lines 4 to 7 |
| irq | output | 1 | Interrupt request, high while any bit is pending |

## Verification
The bench builds the block with its default parameters: four outputs, four inputs and a two-stage synchroniser. With these values the whole configuration byte and the whole pad set are in use, and every trigger code can be placed on a real input in one run. A reference model that tracks the two-cycle synchroniser delay and the one-cycle edge delay is compared with the read data, the outputs and the interrupt on every clock. This also covers the coincident edge-and-clear case and the partial write-one-to-clear case at the exact cycle where each takes effect.

// File: rtl/fixgpio_pkg.sv
package fixgpio_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned OUT_CNT  = 4;
    localparam int unsigned IN_CNT   = 4;
    localparam int unsigned TRIG_W   = 2;
    localparam int unsigned SYNC_LEN = 2;

    localparam logic [ADDR_W-1:0] OFF_DIR  = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_TRIG = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_PEND = 3'd4;

    // Field layout: bit 1 arms rising edges, bit 0 arms falling edges.
    typedef struct packed {
        logic rise_en;
        logic fall_en;
    } trig_t;

    typedef enum logic [2:0] {
        SEL_DIR,
        SEL_DATA,
        SEL_TRIG,
        SEL_PEND,
        SEL_NONE
    } sel_e;

    function automatic sel_e decode_addr(input logic [ADDR_W-1:0] a);
        sel_e s;
        case (a)
            OFF_DIR:  s = SEL_DIR;
            OFF_DATA: s = SEL_DATA;
            OFF_TRIG: s = SEL_TRIG;
            OFF_PEND: s = SEL_PEND;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic edge_hit(input trig_t t, input logic prev,
                                      input logic cur);
        return (t.rise_en & ~prev & cur) | (t.fall_en & prev & ~cur);
    endfunction

endpackage

// File: rtl/fixgpio_sync.sv
module fixgpio_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fixgpio_edge.sv
module fixgpio_edge
    import fixgpio_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          level,
    input  logic [N*TRIG_W-1:0]   trig_bits,
    output logic [N-1:0]          event_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    for (genvar k = 0; k < N; k++) begin : g_pin
        trig_t cfg;
        assign cfg        = trig_t'(trig_bits[k*TRIG_W +: TRIG_W]);
        assign event_o[k] = edge_hit(cfg, prev_q[k], level[k]);
    end
endmodule

// File: rtl/fixgpio_pend.sv
module fixgpio_pend #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o,
    output logic         any_o
);
    logic [N-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;
    assign any_o  = |pend_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0)); // R7
    AST_HOLD_UNCLEARED: assert property (@(posedge clk) disable iff (rst)
        (|(pend_q & ~clr_i)) |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i))); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R8
endmodule

// File: rtl/fixgpio_irq.sv
module fixgpio_irq
    import fixgpio_pkg::*;
#(
    parameter int unsigned N_OUT       = OUT_CNT,
    parameter int unsigned N_IN        = IN_CNT,
    parameter int unsigned SYNC_STAGES = SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [N_OUT-1:0]  pad_out,
    input  logic [N_IN-1:0]   pad_in,
    output logic              irq
);
    localparam int unsigned          CFG_W   = N_IN * TRIG_W;
    localparam logic [BYTE_W-1:0]    DIR_VAL = BYTE_W'((1 << N_OUT) - 1);

    sel_e              sel;
    logic [N_OUT-1:0]  out_q;
    logic [CFG_W-1:0]  trig_q;
    logic [N_IN-1:0]   in_lvl;
    logic [N_IN-1:0]   edge_ev;
    logic [N_IN-1:0]   clr_vec;
    logic [N_IN-1:0]   pend;
    logic              pend_any;

    assign sel = decode_addr(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            trig_q <= '0;
        end else if (bus_we) begin
            if (sel == SEL_DATA) out_q  <= bus_wdata[N_OUT-1:0];
            if (sel == SEL_TRIG) trig_q <= bus_wdata[CFG_W-1:0];
        end
    end

    assign clr_vec = (bus_we && sel == SEL_PEND) ? bus_wdata[N_IN-1:0] : '0;

    fixgpio_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(pad_in), .dout(in_lvl)
    );

    fixgpio_edge #(.N(N_IN)) u_edge (
        .clk(clk), .rst(rst), .level(in_lvl), .trig_bits(trig_q),
        .event_o(edge_ev)
    );

    fixgpio_pend #(.N(N_IN)) u_pend (
        .clk(clk), .rst(rst), .set_i(edge_ev), .clr_i(clr_vec),
        .pend_o(pend), .any_o(pend_any)
    );

    always_comb begin
        case (sel)
            SEL_DIR:  bus_rdata = DIR_VAL;
            SEL_DATA: bus_rdata = BYTE_W'({in_lvl, out_q});
            SEL_TRIG: bus_rdata = BYTE_W'(trig_q);
            SEL_PEND: bus_rdata = BYTE_W'(pend);
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out = out_q;
    assign irq     = pend_any;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (pad_out == '0 && !irq)); // R1
    AST_OUT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFF_DATA) |=> $stable(pad_out)); // R3
    AST_IRQ_VS_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_PEND) |-> ((bus_rdata != '0) == irq)); // R9
    AST_DIR_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_DIR) |-> (bus_rdata == 8'h0F)); // R2
endmodule

// File: tb/fixgpio_irq_bench.sv
`timescale 1ns/100ps
module fixgpio_irq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] pad_out;
    logic [3:0] pad_in = '0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    fixgpio_irq u_fixgpio_irq (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
        .pad_in(pad_in), .irq(irq)
    );

    // Behavioural reference state
    logic [3:0] m_out, m_s1, m_s2, m_prev, m_pend;
    logic [7:0] m_cfg;

    always @(posedge clk) begin
        logic [3:0] ev, clr;
        if (rst) begin
            m_out = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_cfg = 0;
        end else begin
            for (int k = 0; k < 4; k++) begin
                bit rise_ok, fall_ok;
                rise_ok = m_cfg[2*k+1] && !m_prev[k] && m_s2[k];
                fall_ok = m_cfg[2*k]   && m_prev[k] && !m_s2[k];
                ev[k] = rise_ok || fall_ok;
            end
            clr = (bus_we && bus_addr == 3'd4) ? bus_wdata[3:0] : 4'h0;
            m_pend = (m_pend & ~clr) | ev;
            if (bus_we && bus_addr == 3'd1) m_out = bus_wdata[3:0];
            if (bus_we && bus_addr == 3'd3) m_cfg = bus_wdata;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return 8'h0F;
            3'd1: return {m_s2, m_out};
            3'd3: return m_cfg;
            3'd4: return {4'h0, m_pend};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R4";
            3'd3: return "R5";
            3'd4: return "R7";
            default: return "R10";
        endcase
    endfunction

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (bus_rdata !== model_read(bus_addr)) begin
                fails++;
                $display("FAIL %s model read addr=%0d actual=%h expected=%h",
                         read_tag(bus_addr), bus_addr, bus_rdata, model_read(bus_addr));
            end
            checks++;
            if (pad_out !== m_out) begin
                fails++;
                $display("FAIL R3 model pad_out actual=%h expected=%h", pad_out, m_out);
            end
            checks++;
            if (irq !== (m_pend != 0)) begin
                fails++;
                $display("FAIL R9 model irq actual=%b expected=%b", irq, m_pend != 0);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        #0.5;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s read addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_out(input logic [3:0] exp, input string tag);
        checks++;
        if (pad_out !== exp) begin
            fails++;
            $display("FAIL %s pad_out actual=%h expected=%h", tag, pad_out, exp);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        ticks(3);
        chk_out(4'h0, "R1 reset pad_out");
        chk_bit(irq, 1'b0, "R1 reset irq");
        rst = 1'b0;
        tick();
        chk_rd(3'd1, 8'h00, "R1 data after reset");
        chk_rd(3'd3, 8'h00, "R1 trigger after reset");
        chk_rd(3'd4, 8'h00, "R1 pending after reset");
        chk_bit(irq, 1'b0, "R1 irq after reset");

        // R2: fixed direction word
        wr(3'd0, 8'hFF);
        chk_rd(3'd0, 8'h0F, "R2 direction fixed");

        // R3: output write, upper bits ignored
        wr(3'd1, 8'hA5);
        chk_out(4'h5, "R3 output write");
        chk_rd(3'd1, 8'h05, "R3 data readback");

        // R10: unmapped offsets
        wr(3'd2, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        chk_rd(3'd2, 8'h00, "R10 offset 2");
        chk_rd(3'd5, 8'h00, "R10 offset 5");
        chk_rd(3'd6, 8'h00, "R10 offset 6");
        chk_rd(3'd7, 8'h00, "R10 offset 7");
        chk_rd(3'd3, 8'h00, "R10 trigger untouched");
        chk_out(4'h5, "R10 pad_out untouched");

        // R5: in0 rising, in1 falling, in2 masked, in3 both
        wr(3'd3, 8'hC6);
        chk_rd(3'd3, 8'hC6, "R5 trigger readback");

        // R6 and R4: rising edge on input 0 with latency
        pad_in[0] = 1'b1;
        tick();
        chk_rd(3'd1, 8'h05, "R4 level not yet visible");
        tick();
        chk_rd(3'd4, 8'h00, "R6 pending not yet set");
        tick();
        chk_rd(3'd4, 8'h01, "R6 rising sets pending");
        chk_rd(3'd1, 8'h15, "R4 synchronised level");
        chk_bit(irq, 1'b1, "R9 irq with pending");

        wr(3'd4, 8'h01);
        chk_rd(3'd4, 8'h00, "R7 clear input 0");
        chk_bit(irq, 1'b0, "R9 irq drops");
        pad_in[0] = 1'b0;
        ticks(4);
        chk_rd(3'd4, 8'h00, "R6 rising-only ignores fall");

        // falling-only on input 1
        pad_in[1] = 1'b1;
        ticks(4);
        chk_rd(3'd4, 8'h00, "R6 falling-only ignores rise");
        pad_in[1] = 1'b0;
        ticks(4);
        chk_rd(3'd4, 8'h02, "R6 falling sets pending");

        // masked input 2
        pad_in[2] = 1'b1;
        ticks(4);
        pad_in[2] = 1'b0;
        ticks(4);
        chk_rd(3'd4, 8'h02, "R6 masked input silent");

        // both edges on input 3
        pad_in[3] = 1'b1;
        ticks(4);
        chk_rd(3'd4, 8'h0A, "R6 both: rise");
        wr(3'd4, 8'h08);
        chk_rd(3'd4, 8'h02, "R7 partial clear");
        pad_in[3] = 1'b0;
        ticks(4);
        chk_rd(3'd4, 8'h0A, "R6 both: fall");

        // R7: zeros have no effect, ones clear selectively
        wr(3'd4, 8'h00);
        chk_rd(3'd4, 8'h0A, "R7 zero write keeps");
        wr(3'd4, 8'hF2);
        chk_rd(3'd4, 8'h08, "R7 clear bit 1 only");
        chk_bit(irq, 1'b1, "R9 irq still high");

        // R8: edge coincides with clear of the same bit
        pad_in[3] = 1'b1;
        tick();
        tick();
        bus_addr = 3'd4; bus_wdata = 8'h08; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
        chk_rd(3'd4, 8'h08, "R8 set wins over clear");
        wr(3'd4, 8'h08);
        chk_rd(3'd4, 8'h00, "R7 final clear");
        chk_bit(irq, 1'b0, "R9 irq low when empty");

        ticks(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule